// File: doc/BRIEF.md
# Maskable Clear-On-Read Interrupt Status Register

This block gathers single-cycle event pulses from the transmit, receive, DMA and flow-control logic of a network controller. It holds them in sticky status bits and drives one interrupt line from them. An external mask vector chooses which events may set their bit. A mask bit of 0 lets the event through, and a 1 blocks it. The mask register, the DMA engine and the pause timer live outside the block. They reach it only as mask bits and event pulses.

Software sees the status through a small register-bus slave port. A read at the register's address returns the held status in the same cycle. The read also clears every bit on the clock edge that ends it. A write at that address loads the implemented bits straight from the write data whatever the mask says, which lets a test force any pattern of bits. The interrupt output is registered. It follows the OR of the status bits one cycle later.

Top module: `irq_status_reg`

## Requirements
- R1: After synchronous active-low reset every status bit is 0 and `irq` is low.
- R2: An event pulse on an implemented bit whose mask bit is 0 sets that status bit at the next clock edge. The bit then stays set until a read or write changes it.
- R3: An event pulse whose mask bit is 1 never sets its status bit.
- R4: When `bus_rd` is high and `bus_addr` equals `REG_ADDR`, `bus_rdata` shows the held status in the same cycle. At all other times `bus_rdata` is 0.
- R5: A read at `REG_ADDR` clears all status bits on the clock edge that ends the read.
- R6: An enabled event that arrives in the same cycle as a clearing read leaves its bit set after that edge.
- R7: A write at `REG_ADDR` loads every implemented bit from `bus_wdata`, whatever the mask and the prior status.
- R8: In a write cycle the written value wins. Events in the same cycle are ignored, and a read in the same cycle does not clear.
- R9: Implemented bits form mask 0x3CFF. Bit 13 is pause timer zero, 12 is pause frame received, 11 is DMA not-OK response and 10 is receive overrun. Bits 7 down to 0 are transmit complete, transmit buffers exhausted, retry limit, transmit underrun, transmit used-bit read, receive used-bit read, receive complete and management frame sent. Bits 31:14, 9 and 8 always read 0 and ignore both writes and events.
- R10: `irq` equals the OR of the status bits as they stood one clock earlier.
- R11: Reads and writes at any address other than `REG_ADDR` leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register-bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the read cycle |
| evt | input | DATA_W | Event pulses, one per status bit position |
| mask | input | DATA_W | Event mask, 1 blocks the event |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each strobe lasts exactly one cycle per access and that the event and mask inputs are stable around the clock edge. They also assume that a write and a read at the register may coincide, with the write taking over. The stimulus drives every input on the falling edge. It mixes directed collisions of events with reads and writes against a random phase. In that phase the events, the mask, the address and the strobes vary freely, including simultaneous read and write, so every priority path is reached while the inputs stay within those assumptions.

// File: rtl/irq_stat_pkg.sv
// Package: shared constants for the interrupt status register.
// Assumes a 32-bit register whose implemented bits are fixed by the
// event sources wired to it.
package irq_stat_pkg;
    localparam int unsigned STAT_W = 32;
    // Implemented status bits: 13..10 and 7..0
    localparam logic [STAT_W-1:0] IMPL_BITS = 32'h0000_3CFF;
    // Bit indices of the event sources
    localparam int unsigned B_MGMT_SENT  = 0;
    localparam int unsigned B_RX_DONE    = 1;
    localparam int unsigned B_RX_USEDBIT = 2;
    localparam int unsigned B_TX_USEDBIT = 3;
    localparam int unsigned B_TX_UNDER   = 4;
    localparam int unsigned B_RETRY_LIM  = 5;
    localparam int unsigned B_TX_NOBUF   = 6;
    localparam int unsigned B_TX_DONE    = 7;
    localparam int unsigned B_RX_OVR     = 10;
    localparam int unsigned B_DMA_NOK    = 11;
    localparam int unsigned B_PAUSE_RX   = 12;
    localparam int unsigned B_PAUSE_ZERO = 13;
endpackage

// File: rtl/irq_addr_decode.sv
// Module: irq_addr_decode
// Turns the bus strobes into read-hit and write-hit for the single status
// register. Assumes strobes are one-cycle pulses per access.
module irq_addr_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              rd_hit,
    output logic              wr_hit
);
    logic sel;

    // Address match and strobe qualification
    always_comb begin
        sel    = (bus_addr == REG_ADDR);
        rd_hit = sel && bus_rd;
        wr_hit = sel && bus_wr;
    end
endmodule

// File: rtl/irq_status_cell.sv
// Module: irq_status_cell
// One sticky status bit. Priority: test write, then enabled event,
// then clear-on-read. Assumes events are single-cycle pulses.
module irq_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic blk,
    input  logic rd_clr,
    input  logic wr_ld,
    input  logic wr_val,
    output logic q
);
    // Sticky bit update with write > event > read-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (wr_ld) begin
            q <= wr_val;
        end else if (evt && !blk) begin
            q <= 1'b1;
        end else if (rd_clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Array of status cells; only positions set in IMPL get a cell, the rest
// are tied to zero. Assumes rd_clr and wr_ld come from the address decode.
module irq_status_bank #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic [DATA_W-1:0] mask,
    input  logic              rd_clr,
    input  logic              wr_ld,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] status
);
    logic unused_resv;

    // Reserved positions carry no state; fold their inputs away
    assign unused_resv = ^((evt | mask | wr_data) & ~IMPL);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_cell
            irq_status_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (evt[i]),
                .blk    (mask[i]),
                .rd_clr (rd_clr),
                .wr_ld  (wr_ld),
                .wr_val (wr_data[i]),
                .q      (status[i])
            );
        end else begin : g_resv
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_out_reg.sv
// Module: irq_out_reg
// Registered OR of all status bits driving the interrupt line.
// Assumes the status vector is itself registered.
module irq_out_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status,
    output logic              irq
);
    // Register the any-bit-set condition
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |status;
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module: irq_status_reg (top)
// Maskable, clear-on-read interrupt status register with a test write path
// and one registered interrupt output. Assumes one-cycle bus strobes and
// one-cycle event pulses, all synchronous to clk.
module irq_status_reg
    import irq_stat_pkg::*;
#(
    parameter int unsigned DATA_W   = STAT_W,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24,
    parameter logic [DATA_W-1:0] VALID_MASK = IMPL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] evt,
    input  logic [DATA_W-1:0] mask,
    output logic              irq
);
    logic              rd_hit;
    logic              wr_hit;
    logic [DATA_W-1:0] status_q;

    irq_addr_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit)
    );

    irq_status_bank #(
        .DATA_W (DATA_W),
        .IMPL   (VALID_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .mask    (mask),
        .rd_clr  (rd_hit),
        .wr_ld   (wr_hit),
        .wr_data (bus_wdata),
        .status  (status_q)
    );

    irq_out_reg #(
        .DATA_W (DATA_W)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .irq    (irq)
    );

    // Return the pre-clear status during a read hit, zero otherwise
    always_comb begin
        bus_rdata = rd_hit ? status_q : '0;
    end
endmodule

// File: rtl/irq_status_chk.sv
// Module: irq_status_chk
// Property checker bound to irq_status_reg. Assumes one-cycle strobes.
module irq_status_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24,
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] evt,
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] status,
    input logic              irq
);
    logic c_rd;
    logic c_wr;
    assign c_rd = bus_rd && (bus_addr == REG_ADDR);
    assign c_wr = bus_wr && (bus_addr == REG_ADDR);

    // R3
    masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wr |=> ((status & ~$past(status) & $past(mask)) == '0));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && !c_wr) |=> ((status & ~$past(evt & ~mask)) == '0));

    // R7
    write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr |=> (status == $past(bus_wdata & VALID)));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~VALID) == '0);

    // R4
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rd |-> (bus_rdata == '0));

    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == |$past(status)));
endmodule

bind irq_status_reg irq_status_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .VALID    (VALID_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt       (evt),
    .mask      (mask),
    .status    (status_q),
    .irq       (irq)
);

// File: tb/test_irq_status_reg.sv
`timescale 1ns/1ps
module test_irq_status_reg;
    localparam logic [7:0]  RA = 8'h24;
    localparam logic [31:0] VM = 32'h0000_3CFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt = '0;
    logic [31:0] mask = '1;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m_stat = '0;
    logic        m_irq = 1'b0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_reg i_irq_status_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt(evt), .mask(mask), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus/event cycle against the reference model; called at negedge
    task automatic step(input logic [7:0] a, input logic rd, input logic wr,
                        input logic [31:0] wd, input logic [31:0] ev,
                        input logic [31:0] mk, input string tag);
        logic [31:0] exp_rd;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; evt = ev; mask = mk;
        #1;
        exp_rd = (rd && a == RA) ? m_stat : 32'h0;
        check(bus_rdata, exp_rd, tag);
        check({31'h0, irq}, {31'h0, m_irq}, "R10 irq");
        @(posedge clk);
        m_irq = |m_stat;
        if (wr && a == RA) begin
            m_stat = wd & VM;
        end else begin
            if (rd && a == RA) m_stat = 32'h0;
            m_stat = m_stat | (ev & ~mk & VM);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, "R4 idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check({31'h0, irq}, 32'h0, "R1 irq");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R1 read");

        // R2: enabled event sets and stays
        step(RA, 1'b0, 1'b0, 32'h0, 32'h1, 32'hFFFF_FFFE, "R2 event");
        idle(); idle();
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R2 sticky read");
        // R5: cleared by previous read
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R5 after clear");
        idle();

        // R3: all events masked
        step(8'h00, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 masked");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R3 read");

        // R6: event with read in the same cycle
        step(RA, 1'b0, 1'b0, 32'h0, 32'h0000_0080, 32'h0, "R6 prime");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0000_2000, 32'h0, "R6 collide");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R6 bit kept");

        // R7: write overrides mask
        step(RA, 1'b0, 1'b1, 32'h0000_3CFF, 32'h0, '1, "R7 write");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R7 read");
        step(RA, 1'b0, 1'b1, 32'h0000_0400, 32'h0, '1, "R7 write one");
        step(RA, 1'b0, 1'b1, 32'h0000_0000, 32'h0, '1, "R7 write zero");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R7 read zero");

        // R8: write wins over event and over read
        step(RA, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0002, 32'h0, "R8 write+event");
        step(RA, 1'b1, 1'b1, 32'h0000_1000, 32'h0, '1, "R8 write+read");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R8 read");

        // R9: reserved bits ignore writes and events
        step(RA, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, '1, "R9 write all");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R9 read");
        step(RA, 1'b0, 1'b0, 32'h0, 32'hFFFF_C300, 32'h0, "R9 resv events");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R9 read resv");

        // R11: other addresses have no effect
        step(RA, 1'b0, 1'b1, 32'h0000_0020, 32'h0, '1, "R11 load");
        step(8'h20, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R11 foreign read");
        step(8'h28, 1'b0, 1'b1, 32'h0000_3CFF, 32'h0, '1, "R11 foreign write");
        step(RA, 1'b1, 1'b0, 32'h0, 32'h0, '1, "R11 read");
        idle(); idle();

        // Random phase: all collisions and masks
        for (int k = 0; k < 400; k++) begin
            logic [7:0] a;
            a = ($urandom % 3 == 0) ? 8'h20 : RA;
            step(a, ($urandom % 4) == 0, ($urandom % 8) == 0, $urandom,
                 $urandom & $urandom, $urandom | $urandom, "R4 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule